// File: doc/BRIEF.md
# Sprite Output Slot with Horizontal Down-Counter

This unit is one of eight identical per-line sprite output slots. During horizontal blanking, upstream logic fills it with a single load strobe. That strobe carries an X start position, a priority bit, a two-bit palette set and the two bitplane bytes of one already-flipped pattern row. During the visible part of the line, a pixel-enable pulse arrives once per screen pixel. While the slot's X counter is nonzero, each pulse moves the counter one step toward zero. Once the counter sits at zero, the slot is live and each pulse shifts both bitplanes one place left.

The slot emits a packed five-bit word every cycle. The word holds the priority bit, the palette set and the current two-bit pixel. A downstream priority encoder treats a pixel of 00 as transparent. A slot with nothing assigned is loaded with zero planes, so it stays transparent for the whole line. Upstream decoding takes the priority from attribute bit 5 and the palette set from attribute bits 1-0. This slot receives those fields already separated.

Top module: `sprite_slot`

## Requirements
- R1: While rst_n is low, and after its release, word reads 5'b00000. The slot then behaves as a transparent slot whose counter is zero.
- R2: When load is high at a clock edge, X, priority, palette and both planes are all captured at that one edge. Load takes precedence over pix_en in the same cycle.
- R3: While the X counter is nonzero, active is low, the pixel field (word[1:0]) is 2'b00, and each pix_en edge lowers the counter by one.
- R4: Once the counter reaches zero, active is high and stays high until the next load. The pixel field is {plane1 MSB, plane0 MSB}, with bit 1 taken from plane1 and bit 0 from plane0.
- R5: While active, each pix_en edge shifts both planes left with zero fill. Pattern bits therefore appear from bit 7 down to bit 0, one per enabled pixel.
- R6: After all eight pattern bits have been shifted out, the pixel field stays 2'b00 until the next load.
- R7: word[4] is the loaded priority bit, word[3:2] is the loaded palette set, and word[1:0] is the pixel.
- R8: A cycle in which neither load nor pix_en is high leaves word and active unchanged.
- R9: A slot loaded with two all-zero planes outputs pixel 2'b00 for every pixel position of the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture strobe for the slot contents |
| ld_x | input | XW | X start position (pixels until the slot goes live) |
| ld_prio | input | 1 | Priority bit taken from attribute bit 5 |
| ld_pal | input | 2 | Palette set taken from attribute bits 1-0 |
| ld_plane0 | input | PW | Low bitplane of the pattern row |
| ld_plane1 | input | PW | High bitplane of the pattern row |
| pix_en | input | 1 | One pulse per screen pixel |
| active | output | 1 | High once the X counter has reached zero |
| word | output | 5 | {priority, palette[1:0], pixel[1:0]} |

## Verification
All outputs are combinational decodes of registers, so every result is due in the same cycle as the clock edge that updates state. That means one edge after a load, or one edge after each enabled pixel. The bench drives inputs after a falling edge and updates its model at the next rising edge. It then compares word and active at the following falling edge. The expected pixel comes from the count of enabled edges since the last load, measured against the loaded X. Before X such edges the pixel is 00. After X edges it is plane bit 7-k at step k, and after X+8 edges it is 00 again.

// File: rtl/sprite_slot.sv
module sprite_slot #(
  parameter int XW = 8,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [XW-1:0] ld_x,
  input  logic          ld_prio,
  input  logic [1:0]    ld_pal,
  input  logic [PW-1:0] ld_plane0,
  input  logic [PW-1:0] ld_plane1,
  input  logic          pix_en,
  output logic          active,
  output logic [4:0]    word
);
  localparam int MSB = PW - 1;

  logic [XW-1:0] xcnt;
  logic [PW-1:0] sh0, sh1;
  logic          prio;
  logic [1:0]    pal;

  assign active = (xcnt == '0);
  assign word   = {prio, pal, active ? {sh1[MSB], sh0[MSB]} : 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xcnt <= '0;
      sh0  <= '0;
      sh1  <= '0;
      prio <= 1'b0;
      pal  <= 2'b00;
    end else if (load) begin
      xcnt <= ld_x;
      sh0  <= ld_plane0;
      sh1  <= ld_plane1;
      prio <= ld_prio;
      pal  <= ld_pal;
    end else if (pix_en) begin
      if (!active) begin
        xcnt <= xcnt - 1'b1;
      end else begin
        sh0 <= {sh0[MSB-1:0], 1'b0};
        sh1 <= {sh1[MSB-1:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sprite_slot_chk.sv
module sprite_slot_chk #(
  parameter int XW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic [XW-1:0] ld_x,
  input logic          ld_prio,
  input logic [1:0]    ld_pal,
  input logic          pix_en,
  input logic          active,
  input logic [4:0]    word
);
  p_load_zero_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load && ld_x == '0 |=> active);

  p_load_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load && ld_x != '0 |=> !active && word[1:0] == 2'b00);

  p_stay_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active && !load |=> active);

  p_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> word[4] == $past(ld_prio) && word[3:2] == $past(ld_pal));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !pix_en |=> $stable(word) && $stable(active));
endmodule

bind sprite_slot sprite_slot_chk #(.XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .ld_x(ld_x), .ld_prio(ld_prio),
  .ld_pal(ld_pal), .pix_en(pix_en), .active(active), .word(word)
);

// File: tb/tb_sprite_slot.sv
module tb_sprite_slot;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [7:0] ld_x = '0;
  logic       ld_prio = 1'b0;
  logic [1:0] ld_pal = '0;
  logic [7:0] ld_plane0 = '0;
  logic [7:0] ld_plane1 = '0;
  logic       pix_en = 1'b0;
  logic       active;
  logic [4:0] word;

  int tests = 0;
  int fails = 0;

  int         m_x = 0;
  int         m_e = 0;
  logic       m_prio = 1'b0;
  logic [1:0] m_pal = '0;
  logic [7:0] m_p0 = '0;
  logic [7:0] m_p1 = '0;

  always #10 clk = ~clk;

  sprite_slot dut (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_x(ld_x), .ld_prio(ld_prio),
    .ld_pal(ld_pal), .ld_plane0(ld_plane0), .ld_plane1(ld_plane1),
    .pix_en(pix_en), .active(active), .word(word)
  );

  function automatic logic [1:0] exp_pix(int x, int e, logic [7:0] p0, logic [7:0] p1);
    int k;
    if (e < x) return 2'b00;
    k = e - x;
    if (k >= 8) return 2'b00;
    return {p1[7-k], p0[7-k]};
  endfunction

  task automatic check(string tag);
    logic [4:0] ew;
    logic       ea;
    string      rq;
    ew = {m_prio, m_pal, exp_pix(m_x, m_e, m_p0, m_p1)};
    ea = (m_e >= m_x);
    if (tag != "") rq = tag;
    else if (m_e < m_x) rq = "R3";
    else if (m_e - m_x < 8) rq = "R5";
    else rq = "R6";
    tests++;
    if (word !== ew) begin
      fails++;
      $display("FAIL %s/R7 word actual=%b expected=%b", rq, word, ew);
    end
    tests++;
    if (active !== ea) begin
      fails++;
      $display("FAIL R4 (%s) active actual=%b expected=%b", rq, active, ea);
    end
  endtask

  task automatic step(logic l, logic [7:0] x, logic pr, logic [1:0] pa,
                      logic [7:0] p0, logic [7:0] p1, logic en, string tag);
    load = l; ld_x = x; ld_prio = pr; ld_pal = pa;
    ld_plane0 = p0; ld_plane1 = p1; pix_en = en;
    @(posedge clk);
    if (l) begin
      m_x = x; m_e = 0; m_prio = pr; m_pal = pa; m_p0 = p0; m_p1 = p1;
    end else if (en && m_e < 1000) begin
      m_e++;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #4ms;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    @(negedge clk);
    tests++;
    if (word !== 5'b0) begin
      fails++;
      $display("FAIL R1 word in reset actual=%b expected=00000", word);
    end
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 1, "R1");
    // R4/R5: X=0 goes live at once, MSB first
    step(1, 0, 1, 2'b10, 8'b1010_0110, 8'b1100_0011, 0, "R4");
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, 0, 1, "");
    // R2: load wins over pix_en in the same cycle
    step(1, 3, 0, 2'b01, 8'hFF, 8'h81, 1, "R2");
    // R8: idle cycles hold
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 0, 0, (i % 3) != 1, "");
    // R9: empty slot stays transparent
    step(1, 2, 1, 2'b11, 8'h00, 8'h00, 0, "R9");
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 0, 0, 1, "R9");
    // max X counts down fully
    step(1, 8'd255, 0, 2'b10, 8'h5A, 8'hA5, 0, "R3");
    for (int i = 0; i < 265; i++) step(0, 0, 0, 0, 0, 0, 1, "");
    for (int n = 0; n < 3000; n++) begin
      logic l;
      l = ($urandom_range(0, 11) == 0);
      step(l, 8'($urandom_range(0, 15)), 1'($urandom), 2'($urandom),
           8'($urandom), 8'($urandom), $urandom_range(0, 3) != 0, "");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule